// File: doc/BRIEF.md
# Prioritised Hardware Interrupt Arbiter

This block gathers hardware interrupt events from nine sources into a pending vector and decides which exception the core takes next. Each source has a set strobe and a clear strobe. An external interrupt controller can also deliver an event code, which the block maps onto the internal slots. A core-wide request line stays high while any bit is pending.

The core asks for service by raising a one-cycle take strobe. In that same cycle the arbiter reports a valid flag and a 4-bit exception code, which is the index of the winning slot. It also clears the winning bit on the next clock edge. The selection runs in three tiers. The critical slot is never masked. Machine check is masked only by its own enable. A fixed list that puts timers before the external interrupt is masked by the external enable. The block also holds the core's halted state and releases it on a wake condition.

Top module: `hw_event_arbiter`

## Requirements
- R1: Slot encoding: 0 critical/reset, 1 machine check, 2 external, 3 decrementer, 4 hypervisor decrementer, 5 programmable interval timer, 6 fixed interval timer, 7 watchdog, 8 debug. A set strobe on a slot makes its `pending` bit 1 after the next clock edge, and `irq_req` goes high with it.
- R2: A clear strobe removes only its own slot's bit. `irq_req` falls only when the whole pending vector has become zero.
- R3: During a take, a pending slot 0 wins with code 0 whatever the enables are.
- R4: When slot 0 is not pending, slot 1 is granted only while `mc_enable` is 1.
- R5: When neither tier above wins and `ext_enable` is 1, the winner is the first pending slot in the order 4, 3, 5, 6, 7, 2. Slot 4 takes part only when parameter `HYP_EN` is 1, which is the default.
- R6: A take clears only the winner's bit. The other bits stay set, and `err_code` is zero while `take_valid` is 1.
- R7: Slot 8 can be pending but is never granted.
- R8: With `evt_valid` high, `evt_code` 0 drives slot 2, 1 drives slot 0, 2 drives slot 1 and 3 drives slot 8. `evt_level` 1 sets the slot and 0 clears it. Codes 5 to 7 have no effect.
- R9: `evt_code` 4 with `evt_level` 1 sets no slot and makes `sys_reset_req` high for the following cycle.
- R10: `halt_req` halts the core on the next edge. A halted core resumes on the next edge only when `ext_enable` is 1 and `irq_req` is 1. Otherwise it stays halted.
- R11: A set strobe on the winning slot in the cycle of its take leaves that bit set.
- R12: `take_valid` is 0 when `take` is 0 or when no slot is eligible.
- R13: Synchronous active-high `rst` clears `pending`, `irq_req`, `halted` and `sys_reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 9 | Per-slot set strobes |
| src_clr | input | 9 | Per-slot clear strobes |
| evt_valid | input | 1 | Controller event present |
| evt_code | input | 3 | Controller event code |
| evt_level | input | 1 | 1 sets and 0 clears the mapped slot |
| mc_enable | input | 1 | Machine-check enable mode bit |
| ext_enable | input | 1 | External enable mode bit |
| take | input | 1 | One-cycle service strobe from the core |
| halt_req | input | 1 | Core enters halt |
| take_valid | output | 1 | An exception is granted this cycle |
| take_code | output | 4 | Index of the granted slot |
| err_code | output | 8 | Error code that accompanies a grant, always zero |
| pending | output | 9 | Pending vector |
| irq_req | output | 1 | Any slot pending |
| halted | output | 1 | Core halted state |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
The assertions assume that `take` is a single-cycle strobe, and that the enables do not change in the cycle of a take. They also assume that a set and a clear on the same slot in one cycle are resolved by the set winning. The bench drives every input on the falling clock edge and holds the enables steady over each take. It preloads patterns by pairing an all-ones clear with the pattern's set, so it relies on that set-over-clear resolution on purpose. The main sweep covers all 512 pending patterns under all four enable combinations.

// File: rtl/hwarb_pkg.sv
`timescale 1ns/1ps
package hwarb_pkg;
    localparam int NSRC   = 9;
    localparam int CODE_W = 4;
    localparam int EVT_W  = 3;
    localparam int NTIER2 = 6;

    typedef enum logic [CODE_W-1:0] {
        SLOT_CRIT = 4'd0, SLOT_MCHK = 4'd1, SLOT_EXT  = 4'd2,
        SLOT_DEC  = 4'd3, SLOT_HDEC = 4'd4, SLOT_PIT  = 4'd5,
        SLOT_FIT  = 4'd6, SLOT_WDOG = 4'd7, SLOT_DBG  = 4'd8
    } slot_e;

    typedef enum logic [EVT_W-1:0] {
        EV_IRQ = 3'd0, EV_CRIT = 3'd1, EV_MCHK = 3'd2,
        EV_DBG = 3'd3, EV_CORE_RST = 3'd4
    } evt_e;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } grant_t;

    function automatic logic [NSRC-1:0] slot_bit(input logic [CODE_W-1:0] s);
        return {{(NSRC-1){1'b0}}, 1'b1} << s;
    endfunction
endpackage

// File: rtl/hwarb_evmap.sv
`timescale 1ns/1ps
module hwarb_evmap
    import hwarb_pkg::*;
(
    input  logic             evt_valid,
    input  logic [EVT_W-1:0] evt_code,
    input  logic             evt_level,
    output logic [NSRC-1:0]  evt_set,
    output logic [NSRC-1:0]  evt_clr,
    output logic             core_rst
);
    logic [NSRC-1:0] hit;

    always_comb begin
        hit      = '0;
        core_rst = 1'b0;
        if (evt_valid) begin
            case (evt_code)
                EV_IRQ:      hit = slot_bit(SLOT_EXT);
                EV_CRIT:     hit = slot_bit(SLOT_CRIT);
                EV_MCHK:     hit = slot_bit(SLOT_MCHK);
                EV_DBG:      hit = slot_bit(SLOT_DBG);
                EV_CORE_RST: core_rst = evt_level;
                default:     hit = '0;
            endcase
        end
        evt_set = evt_level ? hit : '0;
        evt_clr = evt_level ? '0 : hit;
    end
endmodule

// File: rtl/hwarb_pending.sv
`timescale 1ns/1ps
module hwarb_pending
    import hwarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_v,
    input  logic [NSRC-1:0] clr_v,
    input  logic [NSRC-1:0] take_clr,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] pend_d;

    // the take clear goes first, then clears, then sets, so a new level survives
    always_comb pend_d = ((pend & ~take_clr) & ~clr_v) | set_v;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_d;
    end
endmodule

// File: rtl/hwarb_select.sv
`timescale 1ns/1ps
module hwarb_select
    import hwarb_pkg::*;
#(
    parameter bit HYP_EN = 1'b1
) (
    input  logic            take,
    input  logic [NSRC-1:0] pend,
    input  logic            mc_en,
    input  logic            ext_en,
    output grant_t          grant
);
    localparam logic [CODE_W-1:0] ORDER [NTIER2] =
        '{SLOT_HDEC, SLOT_DEC, SLOT_PIT, SLOT_FIT, SLOT_WDOG, SLOT_EXT};

    logic [NSRC-1:0] elig;

    generate
        if (HYP_EN) begin : g_hyp
            assign elig = pend;
        end else begin : g_nohyp
            assign elig = pend & ~slot_bit(SLOT_HDEC);
        end
    endgenerate

    always_comb begin
        grant = '0;
        if (take) begin
            if (pend[SLOT_CRIT]) begin
                grant = '{valid: 1'b1, code: SLOT_CRIT};
            end else if (mc_en && pend[SLOT_MCHK]) begin
                grant = '{valid: 1'b1, code: SLOT_MCHK};
            end else if (ext_en) begin
                for (int i = 0; i < NTIER2; i++) begin
                    if (!grant.valid && elig[ORDER[i]]) begin
                        grant.valid = 1'b1;
                        grant.code  = ORDER[i];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hw_event_arbiter.sv
`timescale 1ns/1ps
module hw_event_arbiter
    import hwarb_pkg::*;
#(
    parameter bit HYP_EN = 1'b1,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   src_clr,
    input  logic              evt_valid,
    input  logic [EVT_W-1:0]  evt_code,
    input  logic              evt_level,
    input  logic              mc_enable,
    input  logic              ext_enable,
    input  logic              take,
    input  logic              halt_req,
    output logic              take_valid,
    output logic [CODE_W-1:0] take_code,
    output logic [ERR_W-1:0]  err_code,
    output logic [NSRC-1:0]   pending,
    output logic              irq_req,
    output logic              halted,
    output logic              sys_reset_req
);
    logic [NSRC-1:0] evt_set, evt_clr, take_clr;
    logic            core_rst;
    grant_t          grant;

    hwarb_evmap u_evmap (
        .evt_valid (evt_valid), .evt_code (evt_code), .evt_level (evt_level),
        .evt_set   (evt_set),   .evt_clr  (evt_clr),  .core_rst  (core_rst)
    );

    hwarb_select #(.HYP_EN(HYP_EN)) u_select (
        .take (take), .pend (pending), .mc_en (mc_enable),
        .ext_en (ext_enable), .grant (grant)
    );

    assign take_clr = grant.valid ? slot_bit(grant.code) : '0;

    hwarb_pending u_pending (
        .clk (clk), .rst (rst),
        .set_v (src_set | evt_set), .clr_v (src_clr | evt_clr),
        .take_clr (take_clr), .pend (pending)
    );

    assign take_valid = grant.valid;
    assign take_code  = grant.code;
    assign err_code   = '0;
    assign irq_req    = |pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted        <= 1'b0;
            sys_reset_req <= 1'b0;
        end else begin
            sys_reset_req <= core_rst;
            if (halted) halted <= !(ext_enable && irq_req);
            else        halted <= halt_req;
        end
    end
endmodule

// File: rtl/hwarb_checker.sv
`timescale 1ns/1ps
module hwarb_checker
    import hwarb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_set,
    input logic              evt_valid,
    input logic              mc_enable,
    input logic              ext_enable,
    input logic              take,
    input logic              take_valid,
    input logic [CODE_W-1:0] take_code,
    input logic [NSRC-1:0]   pending,
    input logic              irq_req,
    input logic              halted
);
    AST_SET_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
        (|src_set) |=> irq_req); // R1
    AST_CRIT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (take && pending[0]) |-> (take_valid && take_code == 4'd0)); // R3
    AST_MCHK_MASKED: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_code == 4'd1) |-> mc_enable); // R4
    AST_EXT_TIER_MASKED: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_code >= 4'd2) |-> ext_enable); // R5
    AST_WINNER_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (take_valid && src_set == '0 && !evt_valid) |=> !pending[$past(take_code)]); // R6
    AST_DEBUG_NEVER: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> take_code != 4'd8); // R7
    AST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (halted && ext_enable && irq_req) |=> !halted); // R10
    AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (rst)
        (take && src_set[0]) |=> pending[0]); // R11
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (!take || pending == '0) |-> !take_valid); // R12
endmodule

bind hw_event_arbiter hwarb_checker i_hwarb_checker (
    .clk (clk), .rst (rst), .src_set (src_set), .evt_valid (evt_valid),
    .mc_enable (mc_enable), .ext_enable (ext_enable), .take (take),
    .take_valid (take_valid), .take_code (take_code), .pending (pending),
    .irq_req (irq_req), .halted (halted)
);

// File: tb/test_hw_event_arbiter.sv
`timescale 1ns/1ps
module test_hw_event_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic [8:0] src_set, src_clr;
    logic       evt_valid, evt_level;
    logic [2:0] evt_code;
    logic       mc_enable, ext_enable, take, halt_req;
    logic       take_valid;
    logic [3:0] take_code;
    logic [7:0] err_code;
    logic [8:0] pending;
    logic       irq_req, halted, sys_reset_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hw_event_arbiter i_hw_event_arbiter (
        .clk (clk), .rst (rst), .src_set (src_set), .src_clr (src_clr),
        .evt_valid (evt_valid), .evt_code (evt_code), .evt_level (evt_level),
        .mc_enable (mc_enable), .ext_enable (ext_enable), .take (take),
        .halt_req (halt_req), .take_valid (take_valid), .take_code (take_code),
        .err_code (err_code), .pending (pending), .irq_req (irq_req),
        .halted (halted), .sys_reset_req (sys_reset_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_winner(input logic [8:0] p, input bit mc, input bit ee);
        int ord [6] = '{4, 3, 5, 6, 7, 2};
        if (p[0]) return 0;
        if (mc && p[1]) return 1;
        if (ee) foreach (ord[i]) if (p[ord[i]]) return ord[i];
        return -1;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        src_set = '0; src_clr = '0; evt_valid = 0; evt_code = '0; evt_level = 0;
        take = 0; halt_req = 0;
    endtask

    task automatic load(input logic [8:0] p);
        src_clr = '1; src_set = p;
        step();
        src_clr = '0; src_set = '0;
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        idle(); mc_enable = 0; ext_enable = 0; rst = 1;
        @(negedge clk); step();
        rst = 0;
        // R13 reset state
        chk("R13 pending", pending, 0);
        chk("R13 irq_req", irq_req, 0);
        chk("R13 halted", halted, 0);
        chk("R13 sys_reset_req", sys_reset_req, 0);

        // R1 / R2 set and clear
        src_set = 9'b000100100; step(); src_set = '0;
        chk("R1 pending", pending, 9'b000100100);
        chk("R1 irq_req", irq_req, 1);
        src_clr = 9'b000000100; step(); src_clr = '0;
        chk("R2 clear one bit", pending, 9'b000100000);
        chk("R2 irq_req held", irq_req, 1);
        src_clr = 9'b000100000; step(); src_clr = '0;
        chk("R2 irq_req drop", irq_req, 0);

        // R8 event mapping (slot per code 0..3), and ignored codes
        for (int c = 0; c < 8; c++) begin
            int slot;
            load('0);
            evt_valid = 1; evt_level = 1; evt_code = 3'(c);
            step(); idle();
            slot = (c == 0) ? 2 : (c == 1) ? 0 : (c == 2) ? 1 : (c == 3) ? 8 : -1;
            chk("R8 event set", pending, slot < 0 ? 0 : (1 << slot));
            if (c == 4) begin
                chk("R9 reset pulse", sys_reset_req, 1);
                step();
                chk("R9 pulse ends", sys_reset_req, 0);
            end else begin
                chk("R9 no reset pulse", sys_reset_req, 0);
            end
            if (slot >= 0) begin
                evt_valid = 1; evt_level = 0; evt_code = 3'(c);
                step(); idle();
                chk("R8 event clear", pending, 0);
            end
        end

        // R11 set in take cycle keeps the bit
        load(9'b000001001);
        take = 1; src_set = 9'b000000001; #1;
        chk("R11 grant crit", take_code, 0);
        step(); idle();
        chk("R11 bit kept", pending, 9'b000001001);

        // R10 halt and wake
        load(9'b000000100); ext_enable = 0;
        halt_req = 1; step(); halt_req = 0;
        chk("R10 halted", halted, 1);
        step();
        chk("R10 stays halted without enable", halted, 1);
        load('0); ext_enable = 1; step();
        chk("R10 stays halted without request", halted, 1);
        src_set = 9'b000000100; step(); src_set = '0;
        step();
        chk("R10 woke", halted, 0);

        // R12 no take strobe
        load(9'b011111111); mc_enable = 1; ext_enable = 1; #1;
        chk("R12 no strobe", take_valid, 0);

        // R3 R4 R5 R6 R7 R12 sweep
        for (int e = 0; e < 4; e++) begin
            for (int p = 0; p < 512; p++) begin
                int w;
                logic [8:0] expp;
                mc_enable = e[0]; ext_enable = e[1];
                load(9'(p));
                w = ref_winner(9'(p), e[0], e[1]);
                take = 1; #1;
                chk("R3 R4 R5 R7 R12 valid", take_valid, w >= 0);
                if (w >= 0) begin
                    chk("R3 R4 R5 R7 code", take_code, w);
                    chk("R6 err_code", err_code, 0);
                end
                step(); take = 0;
                expp = (w >= 0) ? (9'(p) & ~(9'(1) << w)) : 9'(p);
                chk("R6 pending after take", pending, expp);
                chk("R2 irq_req level", irq_req, expp != 0);
            end
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule